// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block lets a host processor reach the control registers inside a PHY through a narrow indirect port. The host sees a handful of 32-bit registers on a simple memory-mapped bus. It places an operand in a shared data-in register and then writes 1 to one of four strobe registers. The strobes are capture-address, capture-data, read and write. The bridge turns each strobe into a one-cycle pulse on a PHY-side control bus. It then waits for the PHY to acknowledge.

Each strobe reads back as 1 while its operation is in flight and clears itself once the acknowledge is sampled, so software can poll it for completion. A PHY write takes three strobed steps: address capture, data capture, then write. A PHY read takes two: address capture, then read. The result lands in a data-out register. The PHY can return stale data on the first read after an address capture, so software issues the read strobe twice and keeps only the second result. Only one operation may be in flight at a time. A strobe that arrives while another is pending is dropped, and a sticky error flag is raised.

Top module: `phycr_bridge`

## Requirements
- R1: After reset, every strobe register, the data-out register and the error flag read 0, and no PHY-side pulse is driven.
- R2: Writing a value with bit 0 set to a strobe register while nothing is pending drives exactly one PHY pulse of the matching type. The pulse lasts one cycle and starts the cycle after the bus write. While the operation is pending, cr_data_in carries bits [15:0] of the data-in register as they were at the strobe.
- R3: A strobe register reads 1 while its operation is pending. It reads 0 from the clock edge at which cr_ack is sampled high onward.
- R4: Writing a value with bit 0 clear to a strobe register has no effect: no pulse is driven, nothing becomes pending and no error is flagged.
- R5: A strobe written while another operation is pending is ignored, and the error flag is set. The flag is bit 0 at offset 0x24. It stays set until the host writes a value with bit 0 set to 0x24.
- R6: The data-out register (offset 0x10, bits [15:0], upper bits 0) loads cr_data_out only when a read operation is acknowledged. It holds its value through any other operation.
- R7: cr_addr takes the captured operand when a capture-address operation is acknowledged and holds its value otherwise.
- R8: Host reads are registered. bus_rdata shows the addressed register one clock edge after bus_rd is sampled. Unused bits and unmapped offsets read 0. Data-in at 0x0C reads back all 32 bits.
- R9: The strobe registers sit at these offsets: capture-address at 0x14, capture-data at 0x18, read at 0x1C and write at 0x20.
- R10: With a PHY that returns stale data on the first read after an address capture, the full write sequence stores a value. A read sequence that strobes read twice then returns that value in data-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host register write enable |
| bus_rd | input | 1 | Host register read enable |
| bus_addr | input | 8 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| cr_addr | output | 16 | Last acknowledged captured address |
| cr_data_in | output | 16 | Operand sent to the PHY |
| cr_data_out | input | 16 | Read data returned by the PHY |
| cr_cap_addr | output | 1 | Capture-address pulse |
| cr_cap_data | output | 1 | Capture-data pulse |
| cr_read | output | 1 | Read pulse |
| cr_write | output | 1 | Write pulse |
| cr_ack | input | 1 | PHY acknowledge of the pending operation |

## Verification
The assertions check several rules on every cycle:
- PHY pulses are one-hot and one cycle wide.
- An acknowledge empties the pending state, and without one the pending state holds.
- The error flag falls only on a clearing write.
- Data-out and cr_addr change only on the acknowledge of their own operation type.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the exact cycle a pulse appears;
- dropped strobes with bit 0 clear;
- the register map and read latency;
- the double-read sequence against a PHY model that answers the first read with stale data.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

  localparam int NUM_OPS = 4;

  // Operation index; also the order of the strobe registers in the map.
  typedef enum logic [1:0] {
    OP_CAPA = 2'd0,
    OP_CAPD = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } cr_op_e;

  localparam logic [7:0] OFF_DIN  = 8'h0C;
  localparam logic [7:0] OFF_DOUT = 8'h10;
  localparam logic [7:0] OFF_STB0 = 8'h14;
  localparam logic [7:0] OFF_ERR  = 8'h24;

  function automatic logic [7:0] strobe_off(input int op);
    return OFF_STB0 + 8'(op * 4);
  endfunction

endpackage

// File: rtl/phycr_hostregs.sv
module phycr_hostregs
  import phycr_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int HOST_DW = 32,
  parameter int CR_DW   = 16,
  parameter int N_OPS   = NUM_OPS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [HOST_AW-1:0] bus_addr,
  input  logic [HOST_DW-1:0] bus_wdata,
  input  logic [N_OPS-1:0]   pend,
  input  logic [CR_DW-1:0]   dout,
  input  logic               conflict,
  output logic [HOST_DW-1:0] din_q,
  output logic [N_OPS-1:0]   start_req,
  output logic               err_q,
  output logic [HOST_DW-1:0] bus_rdata
);

  logic [N_OPS-1:0]   stb_hit;
  logic               hit_din, hit_dout, hit_err;
  logic [HOST_DW-1:0] rd_val;

  assign hit_din  = (bus_addr == HOST_AW'(OFF_DIN));
  assign hit_dout = (bus_addr == HOST_AW'(OFF_DOUT));
  assign hit_err  = (bus_addr == HOST_AW'(OFF_ERR));

  for (genvar i = 0; i < N_OPS; i++) begin : g_stb
    assign stb_hit[i]   = (bus_addr == HOST_AW'(strobe_off(i)));
    assign start_req[i] = bus_wr & stb_hit[i] & bus_wdata[0];
  end

  always_comb begin
    rd_val = '0;
    if (hit_din)  rd_val = din_q;
    if (hit_dout) rd_val = HOST_DW'(dout);
    if (hit_err)  rd_val = HOST_DW'(err_q);
    for (int i = 0; i < N_OPS; i++)
      if (stb_hit[i]) rd_val = HOST_DW'(pend[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q     <= '0;
      err_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && hit_din) din_q <= bus_wdata;
      if (conflict)                           err_q <= 1'b1;
      else if (bus_wr && hit_err && bus_wdata[0]) err_q <= 1'b0;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
  import phycr_pkg::*;
#(
  parameter int CR_AW = 16,
  parameter int CR_DW = 16,
  parameter int N_OPS = NUM_OPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OPS-1:0] start_req,
  input  logic [CR_DW-1:0] operand,
  input  logic             cr_ack,
  input  logic [CR_DW-1:0] cr_data_out,
  output logic [N_OPS-1:0] pend,
  output logic [N_OPS-1:0] pulse,
  output logic [CR_DW-1:0] operand_q,
  output logic [CR_AW-1:0] cr_addr_q,
  output logic [CR_DW-1:0] dout_q,
  output logic             conflict
);

  logic busy, req_any;

  assign busy     = |pend;
  assign req_any  = |start_req;
  assign conflict = req_any & busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      pulse     <= '0;
      operand_q <= '0;
      cr_addr_q <= '0;
      dout_q    <= '0;
    end else begin
      pulse <= '0;
      if (req_any && !busy) begin
        pend      <= start_req;
        pulse     <= start_req;
        operand_q <= operand;
      end else if (busy && cr_ack) begin
        pend <= '0;
        if (pend[OP_CAPA]) cr_addr_q <= operand_q[CR_AW-1:0];
        if (pend[OP_RD])   dout_q    <= cr_data_out;
      end
    end
  end

endmodule

// File: rtl/phycr_bridge.sv
module phycr_bridge
  import phycr_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int HOST_DW = 32,
  parameter int CR_AW   = 16,
  parameter int CR_DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [HOST_AW-1:0] bus_addr,
  input  logic [HOST_DW-1:0] bus_wdata,
  output logic [HOST_DW-1:0] bus_rdata,
  output logic [CR_AW-1:0]   cr_addr,
  output logic [CR_DW-1:0]   cr_data_in,
  input  logic [CR_DW-1:0]   cr_data_out,
  output logic               cr_cap_addr,
  output logic               cr_cap_data,
  output logic               cr_read,
  output logic               cr_write,
  input  logic               cr_ack
);

  logic [HOST_DW-1:0] din_q;
  logic [NUM_OPS-1:0] start_req, pend, pulse;
  logic [CR_DW-1:0]   dout_q;
  logic               err_q, conflict;

  phycr_hostregs #(
    .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .CR_DW(CR_DW), .N_OPS(NUM_OPS)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend(pend), .dout(dout_q),
    .conflict(conflict), .din_q(din_q), .start_req(start_req),
    .err_q(err_q), .bus_rdata(bus_rdata)
  );

  phycr_seq #(
    .CR_AW(CR_AW), .CR_DW(CR_DW), .N_OPS(NUM_OPS)
  ) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .operand(din_q[CR_DW-1:0]),
    .cr_ack(cr_ack), .cr_data_out(cr_data_out), .pend(pend), .pulse(pulse),
    .operand_q(cr_data_in), .cr_addr_q(cr_addr), .dout_q(dout_q),
    .conflict(conflict)
  );

  assign cr_cap_addr = pulse[OP_CAPA];
  assign cr_cap_data = pulse[OP_CAPD];
  assign cr_read     = pulse[OP_RD];
  assign cr_write    = pulse[OP_WR];

endmodule

// File: rtl/phycr_bridge_chk.sv
module phycr_bridge_chk
  import phycr_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int HOST_DW = 32,
  parameter int CR_AW   = 16,
  parameter int CR_DW   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [HOST_AW-1:0] bus_addr,
  input logic [HOST_DW-1:0] bus_wdata,
  input logic [NUM_OPS-1:0] pend,
  input logic [NUM_OPS-1:0] pulse,
  input logic               cr_ack,
  input logic [CR_DW-1:0]   dout_q,
  input logic [CR_AW-1:0]   cr_addr,
  input logic               err_q
);

  // R2
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> !(|pulse));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cr_ack && (|pend)) |=> (pend == '0));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((|pend) && !cr_ack) |=> $stable(pend));

  // R5
  err_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(bus_wr && bus_addr == HOST_AW'(OFF_ERR) && bus_wdata[0]));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cr_ack && pend[OP_RD]) |=> $stable(dout_q));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cr_ack && pend[OP_CAPA]) |=> $stable(cr_addr));

endmodule

bind phycr_bridge phycr_bridge_chk #(
  .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .CR_AW(CR_AW), .CR_DW(CR_DW)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend), .pulse(pulse), .cr_ack(cr_ack),
  .dout_q(dout_q), .cr_addr(cr_addr), .err_q(err_q)
);

// File: tb/sim_phycr_bridge.sv
`timescale 1ns/1ps
module sim_phycr_bridge;

  localparam logic [7:0] A_DIN = 8'h0C, A_DOUT = 8'h10, A_CAPA = 8'h14,
                         A_CAPD = 8'h18, A_RD = 8'h1C, A_WR = 8'h20,
                         A_ERR = 8'h24;
  localparam logic [15:0] STALE = 16'hBAD0;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] cr_addr, cr_data_in, cr_data_out;
  logic        cr_cap_addr, cr_cap_data, cr_read, cr_write, cr_ack;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Behavioural PHY register model
  logic        model_en = 0, man_ack = 0, m_ack = 0, stale = 0;
  logic [15:0] m_addr = '0, m_wd = '0, m_out = '0;
  logic [15:0] mem [16];
  logic [2:0]  cnt = '0;

  assign cr_ack      = m_ack | man_ack;
  assign cr_data_out = m_out;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0;

  always @(posedge clk) begin
    m_ack <= 1'b0;
    if (rst) cnt <= '0;
    else if (model_en && (cr_cap_addr | cr_cap_data | cr_read | cr_write)) begin
      cnt <= 3'd3;
      if (cr_cap_addr) begin m_addr <= cr_data_in; stale <= 1'b1; end
      if (cr_cap_data) m_wd <= cr_data_in;
      if (cr_write) mem[m_addr[3:0]] <= m_wd;
      if (cr_read) begin
        m_out <= stale ? STALE : mem[m_addr[3:0]];
        stale <= 1'b0;
      end
    end else if (cnt != 0) begin
      cnt <= cnt - 1'b1;
      if (cnt == 3'd1) m_ack <= 1'b1;
    end
  end

  phycr_bridge u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cr_addr(cr_addr), .cr_data_in(cr_data_in), .cr_data_out(cr_data_out),
    .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data), .cr_read(cr_read),
    .cr_write(cr_write), .cr_ack(cr_ack)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic poll(input logic [7:0] a);
    logic [31:0] v;
    for (int i = 0; i < 30; i++) begin
      host_read(a, v);
      if (v == 0) return;
    end
    check(0, "R3 strobe never cleared", v, 0);
  endtask

  task automatic phy_write(input logic [15:0] a, input logic [15:0] v);
    host_write(A_DIN, {16'h0, a}); host_write(A_CAPA, 1); poll(A_CAPA);
    host_write(A_DIN, {16'h0, v}); host_write(A_CAPD, 1); poll(A_CAPD);
    host_write(A_WR, 1); poll(A_WR);
  endtask

  task automatic phy_read_once(output logic [31:0] d);
    host_write(A_RD, 1); poll(A_RD);
    host_read(A_DOUT, d);
  endtask

  task automatic pulse_ack;
    @(negedge clk); man_ack = 1;
    @(negedge clk); man_ack = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check({cr_cap_addr, cr_cap_data, cr_read, cr_write} == 0, "R1 pulses", 0, 0);
    host_read(A_CAPA, v); check(v == 0, "R1 capa", v, 0);
    host_read(A_CAPD, v); check(v == 0, "R1 capd", v, 0);
    host_read(A_RD, v);   check(v == 0, "R1 rd", v, 0);
    host_read(A_WR, v);   check(v == 0, "R1 wr", v, 0);
    host_read(A_DOUT, v); check(v == 0, "R1 dout", v, 0);
    host_read(A_ERR, v);  check(v == 0, "R1 err", v, 0);
  endtask

  task automatic t_pulse;
    logic [31:0] v;
    model_en = 0;
    host_write(A_DIN, 32'h1234_ABCD);
    @(negedge clk); bus_wr = 1; bus_addr = A_CAPA; bus_wdata = 1;
    @(negedge clk); bus_wr = 0;
    check({cr_cap_addr, cr_cap_data, cr_read, cr_write} == 4'b1000, "R2 pulse type",
          {cr_cap_addr, cr_cap_data, cr_read, cr_write}, 4'b1000);
    check(cr_data_in == 16'hABCD, "R2 operand", cr_data_in, 16'hABCD);
    @(negedge clk);
    check(cr_cap_addr == 0, "R2 one cycle", cr_cap_addr, 0);
    host_read(A_CAPA, v); check(v == 1, "R3 pending reads 1", v, 1);
    check(cr_addr == 16'h0, "R7 addr before ack", cr_addr, 0);
    pulse_ack;
    host_read(A_CAPA, v); check(v == 0, "R3 cleared on ack", v, 0);
    check(cr_addr == 16'hABCD, "R7 addr after ack", cr_addr, 16'hABCD);
    // R9: other strobe offsets map to their own pulses
    @(negedge clk); bus_wr = 1; bus_addr = A_RD; bus_wdata = 1;
    @(negedge clk); bus_wr = 0;
    check({cr_cap_addr, cr_cap_data, cr_read, cr_write} == 4'b0010, "R9 read strobe",
          {cr_cap_addr, cr_cap_data, cr_read, cr_write}, 4'b0010);
    pulse_ack;
    @(negedge clk); bus_wr = 1; bus_addr = A_CAPD; bus_wdata = 1;
    @(negedge clk); bus_wr = 0;
    check({cr_cap_addr, cr_cap_data, cr_read, cr_write} == 4'b0100, "R9 capd strobe",
          {cr_cap_addr, cr_cap_data, cr_read, cr_write}, 4'b0100);
    pulse_ack;
  endtask

  task automatic t_zero;
    logic [31:0] v;
    @(negedge clk); bus_wr = 1; bus_addr = A_WR; bus_wdata = 32'hFFFF_FFFE;
    @(negedge clk); bus_wr = 0;
    check(cr_write == 0, "R4 no pulse", cr_write, 0);
    host_read(A_WR, v);  check(v == 0, "R4 not pending", v, 0);
    host_read(A_ERR, v); check(v == 0, "R4 no error", v, 0);
  endtask

  task automatic t_conflict;
    logic [31:0] v;
    model_en = 0;
    host_write(A_CAPD, 1);
    host_write(A_WR, 1);
    check(cr_write == 0, "R5 dropped strobe no pulse", cr_write, 0);
    host_read(A_ERR, v); check(v == 1, "R5 error set", v, 1);
    host_read(A_WR, v);  check(v == 0, "R5 write not pending", v, 0);
    host_read(A_CAPD, v); check(v == 1, "R5 original pending", v, 1);
    pulse_ack;
    host_read(A_ERR, v); check(v == 1, "R5 error sticky", v, 1);
    host_write(A_ERR, 1);
    host_read(A_ERR, v); check(v == 0, "R5 error cleared", v, 0);
  endtask

  task automatic t_sequence;
    logic [31:0] v;
    model_en = 1;
    phy_write(16'h0005, 16'hBEEF);
    phy_write(16'h0003, 16'h1357);
    host_write(A_DIN, 32'h5); host_write(A_CAPA, 1); poll(A_CAPA);
    phy_read_once(v); check(v == {16'h0, STALE}, "R10 first read stale", v, STALE);
    phy_read_once(v); check(v == 32'hBEEF, "R10 second read", v, 32'hBEEF);
    host_write(A_DIN, 32'h3); host_write(A_CAPA, 1); poll(A_CAPA);
    phy_read_once(v);
    phy_read_once(v); check(v == 32'h1357, "R10 other reg", v, 32'h1357);
    // R6: write operations leave data-out alone
    phy_write(16'h0007, 16'h2468);
    host_read(A_DOUT, v); check(v == 32'h1357, "R6 dout held", v, 32'h1357);
  endtask

  task automatic t_map;
    logic [31:0] v;
    host_write(A_DIN, 32'hCAFE_F00D);
    host_read(A_DIN, v); check(v == 32'hCAFE_F00D, "R8 din full width", v, 32'hCAFE_F00D);
    @(negedge clk); bus_rd = 1; bus_addr = 8'h00;
    #1 check(bus_rdata == 32'hCAFE_F00D, "R8 registered latency", bus_rdata, 32'hCAFE_F00D);
    @(negedge clk); bus_rd = 0;
    check(bus_rdata == 0, "R8 unmapped 0x00", bus_rdata, 0);
    host_read(8'h04, v); check(v == 0, "R8 unmapped 0x04", v, 0);
    host_read(8'h28, v); check(v == 0, "R8 unmapped 0x28", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_pulse;
    t_zero;
    t_conflict;
    t_sequence;
    t_map;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500us;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule